// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 1 Kbit serial nonvolatile memory that a host reaches over three wires and a select line. The host raises chip select and clocks in a frame: a start bit, a two-bit opcode and an address. Write-type frames also carry a data word. The block decodes seven instructions from these frames:
- read a word or byte;
- write a word or byte;
- erase a word or byte;
- fill the whole array with one value;
- erase the whole array;
- set the programming lock;
- clear the programming lock.

An organisation pin selects how the array is seen: 64 words of 16 bits or 128 bytes.

The chip select and serial clock are sampled into one system clock domain. Edges are found by comparing each sample with the previous one. Reads stream data out on the output line, starting with a single zero bit. The address then advances from word to word until chip select drops. Programming instructions are armed by the frame and start when chip select falls. They then run for a fixed number of system clocks without any serial clock. During that time the data line reports busy or ready whenever chip select is high.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A frame begins with the first 1 sampled while the block is idle; 0 bits before it are skipped. The 1 is followed by 2 opcode bits, then by 6 address bits when `org16_i`=1 or 7 address bits when `org16_i`=0. All fields are sent MSB first.
- R2: Opcode 10 reads, 01 writes and 11 erases. Opcode 00 is decoded from the two most significant address bits: 11 sets the programming lock open, 00 closes it, 10 erases the whole array and 01 fills the whole array with the data word that follows.
- R3: The programming lock is closed after reset. While it is closed, write, erase, fill and erase-all are ignored. Once opened it stays open until the close instruction or a reset.
- R4: A read works whether or not the lock is open. After the last address bit, the output drives one 0 bit, then the data MSB first.
- R5: Serial input is taken on rising serial clock edges, and each new read bit appears after a rising serial clock edge.
- R6: After the last bit of a word, the read continues with the next address. It wraps from the top of the array to address 0 for as long as chip select stays high.
- R7: A programming instruction starts only when chip select falls after a complete frame. It needs no serial clock edges.
- R8: The array resets to all ones. Erase sets the addressed cells to ones. Write replaces the old value without a prior erase.
- R9: While a program cycle runs and chip select is high, the output is enabled and drives 0. After the cycle, it drives 1 once chip select is high again, until the next start bit. With chip select low, the output enable is 0.
- R10: The program cycle lasts `PROG_CYCLES` system clocks.
- R11: Frames sent during a program cycle are ignored. A frame that is cut short by chip select falling has no effect.
- R12: In 8-bit mode, byte address 2k holds bits 7:0 and byte address 2k+1 holds bits 15:8 of 16-bit word k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| org16_i | input | 1 | 1 = 16-bit words, 0 = bytes |
| sdo_o | output | 1 | Serial data out / busy-ready flag |
| sdo_en_o | output | 1 | Output enable; 0 means high impedance |

## Verification
The hardest case to reach is a frame that arrives while a program cycle is still running. In that case the start bit must be ignored, and the write at the end must not be armed. The bench therefore makes the program cycle longer than a complete write frame. It then sends a full write frame while the cycle runs, and drops chip select before the cycle ends. A later read proves the target word is unchanged. Cut-off frames and the wrap across the top of the array in both organisations are driven directly. Random mixes of reads, writes and erases in both modes are compared against a bench model.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_DATA,
        PH_READ,
        PH_HOLD
    } phase_e;

    typedef enum logic [2:0] {
        PG_NONE,
        PG_WRITE,
        PG_ERASE,
        PG_FILL,
        PG_CLEAR
    } prog_e;

endpackage

// File: rtl/serial_eeprom_sync.sv
module serial_eeprom_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_eeprom_timer.sv
module serial_eeprom_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i && cnt_q == '0) cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)       cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CYCLES));
    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);
    assert_load_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> cnt_q == CW'(CYCLES));
endmodule

// File: rtl/serial_eeprom_array.sv
module serial_eeprom_array #(
    parameter int WORD_BITS = 16,
    parameter int IDX_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  logic [1:0]           wr_lane_i,
    input  logic [WORD_BITS-1:0] wr_data_i,
    input  logic                 fill_en_i,
    input  logic [WORD_BITS-1:0] fill_data_i,
    input  logic [IDX_W-1:0]     rd_idx_i,
    output logic [WORD_BITS-1:0] rd_word_o
);
    localparam int WORDS = 1 << IDX_W;
    localparam int LANE  = WORD_BITS / 2;

    logic [WORD_BITS-1:0] mem_q [WORDS];
    logic [WORD_BITS-1:0] mem_d [WORDS];

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = fill_en_i ? fill_data_i : mem_q[i];
        end
        if (wr_en_i) begin
            for (int l = 0; l < 2; l++) begin
                if (wr_lane_i[l]) mem_d[wr_idx_i][l*LANE +: LANE] = wr_data_i[l*LANE +: LANE];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word_o = mem_q[rd_idx_i];

    assert_single_port_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && fill_en_i));
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import serial_eeprom_pkg::*;
#(
    parameter int WORD_BITS   = 16,
    parameter int ADDR16_W    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    input  logic org16_i,
    output logic sdo_o,
    output logic sdo_en_o
);
    localparam int AW8  = ADDR16_W + 1;
    localparam int HB   = AW8 + 2;
    localparam int BW   = WORD_BITS / 2;
    localparam int HCW  = $clog2(HB + 1);
    localparam int DCW  = $clog2(WORD_BITS + 1);

    typedef struct packed {
        phase_e                phase;
        logic                  sel_p;
        logic                  sck_p;
        logic [HB-1:0]         head;
        logic [HCW-1:0]        hcnt;
        logic [WORD_BITS-1:0]  wdat;
        logic [DCW-1:0]        dcnt;
        prog_e                 dkind;
        logic [WORD_BITS-1:0]  rd_sh;
        logic [DCW-1:0]        rcnt;
        logic [AW8-1:0]        addr;
        logic                  sdo_bit;
        prog_e                 pend;
        logic [AW8-1:0]        pend_addr;
        logic [WORD_BITS-1:0]  pend_data;
        logic                  prog_en;
        logic                  rdy_show;
    } state_t;

    state_t q, n;

    logic [2:0] pins_s;
    logic sel_l, sck_l, sdi_l, sel_fall, sck_rise, busy, tmr_start;

    serial_eeprom_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sck_i, sdi_i}),
        .sync_o  (pins_s)
    );
    assign sel_l    = pins_s[2];
    assign sck_l    = pins_s[1];
    assign sdi_l    = pins_s[0];
    assign sel_fall = !sel_l && q.sel_p;
    assign sck_rise = sck_l && !q.sck_p;

    serial_eeprom_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (busy)
    );

    // Header decode and read-address selection
    logic [HB-1:0]        nxt_head;
    logic [1:0]           hdr_op, hdr_top;
    logic [AW8-1:0]       hdr_addr, inc_addr, ld_addr;
    logic [ADDR16_W-1:0]  rd_idx;
    logic [WORD_BITS-1:0] arr_word, ld_val;
    logic [HCW-1:0]       need_h;
    logic [DCW-1:0]       dw;

    always_comb begin
        nxt_head = {q.head[HB-2:0], sdi_l};
        if (org16_i) begin
            hdr_op   = nxt_head[ADDR16_W+1:ADDR16_W];
            hdr_addr = {1'b0, nxt_head[ADDR16_W-1:0]};
            hdr_top  = nxt_head[ADDR16_W-1:ADDR16_W-2];
            inc_addr = {1'b0, q.addr[ADDR16_W-1:0] + 1'b1};
            need_h   = HCW'(ADDR16_W + 2);
            dw       = DCW'(WORD_BITS);
        end else begin
            hdr_op   = nxt_head[AW8+1:AW8];
            hdr_addr = nxt_head[AW8-1:0];
            hdr_top  = nxt_head[AW8-1:AW8-2];
            inc_addr = q.addr + 1'b1;
            need_h   = HCW'(HB);
            dw       = DCW'(BW);
        end
        ld_addr = (q.phase == PH_HEAD) ? hdr_addr : inc_addr;
        rd_idx  = org16_i ? ld_addr[ADDR16_W-1:0] : ld_addr[AW8-1:1];
        if (org16_i) ld_val = arr_word;
        else         ld_val = {(ld_addr[0] ? arr_word[WORD_BITS-1:BW] : arr_word[BW-1:0]), {BW{1'b0}}};
    end

    // Program execution port
    logic                 wr_en, fill_en;
    logic [ADDR16_W-1:0]  wr_idx;
    logic [1:0]           wr_lane;
    logic [WORD_BITS-1:0] wr_data, fill_data, p_dat;
    logic                 do_prog;

    always_comb begin
        do_prog   = sel_fall && (q.pend != PG_NONE) && q.prog_en && !busy;
        wr_idx    = org16_i ? q.pend_addr[ADDR16_W-1:0] : q.pend_addr[AW8-1:1];
        wr_lane   = org16_i ? 2'b11 : (q.pend_addr[0] ? 2'b10 : 2'b01);
        p_dat     = org16_i ? q.pend_data : {2{q.pend_data[BW-1:0]}};
        wr_en     = do_prog && (q.pend == PG_WRITE || q.pend == PG_ERASE);
        wr_data   = (q.pend == PG_WRITE) ? p_dat : '1;
        fill_en   = do_prog && (q.pend == PG_FILL || q.pend == PG_CLEAR);
        fill_data = (q.pend == PG_FILL) ? p_dat : '1;
    end

    serial_eeprom_array #(.WORD_BITS(WORD_BITS), .IDX_W(ADDR16_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_idx_i    (wr_idx),
        .wr_lane_i   (wr_lane),
        .wr_data_i   (wr_data),
        .fill_en_i   (fill_en),
        .fill_data_i (fill_data),
        .rd_idx_i    (rd_idx),
        .rd_word_o   (arr_word)
    );

    // Frame sequencer
    always_comb begin
        n         = q;
        n.sel_p   = sel_l;
        n.sck_p   = sck_l;
        tmr_start = 1'b0;
        if (sel_fall) begin
            if (do_prog) begin
                tmr_start  = 1'b1;
                n.rdy_show = 1'b1;
            end
            n.phase = PH_IDLE;
            n.pend  = PG_NONE;
        end else if (sel_l && sck_rise) begin
            unique case (q.phase)
                PH_IDLE: begin
                    if (sdi_l && !busy) begin
                        n.phase    = PH_HEAD;
                        n.head     = '0;
                        n.hcnt     = '0;
                        n.rdy_show = 1'b0;
                    end
                end
                PH_HEAD: begin
                    n.head = nxt_head;
                    n.hcnt = q.hcnt + 1'b1;
                    if (q.hcnt + 1'b1 == need_h) begin
                        n.phase     = PH_HOLD;
                        n.pend_addr = hdr_addr;
                        n.wdat      = '0;
                        n.dcnt      = '0;
                        unique case (hdr_op)
                            2'b10: begin
                                n.phase   = PH_READ;
                                n.addr    = hdr_addr;
                                n.rd_sh   = ld_val;
                                n.rcnt    = dw;
                                n.sdo_bit = 1'b0;
                            end
                            2'b01: begin
                                n.phase = PH_DATA;
                                n.dkind = PG_WRITE;
                            end
                            2'b11: n.pend = PG_ERASE;
                            default: begin
                                unique case (hdr_top)
                                    2'b11: n.prog_en = 1'b1;
                                    2'b00: n.prog_en = 1'b0;
                                    2'b10: n.pend    = PG_CLEAR;
                                    default: begin
                                        n.phase = PH_DATA;
                                        n.dkind = PG_FILL;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                PH_DATA: begin
                    n.wdat = {q.wdat[WORD_BITS-2:0], sdi_l};
                    n.dcnt = q.dcnt + 1'b1;
                    if (q.dcnt + 1'b1 == dw) begin
                        n.pend      = q.dkind;
                        n.pend_data = {q.wdat[WORD_BITS-2:0], sdi_l};
                        n.phase     = PH_HOLD;
                    end
                end
                PH_READ: begin
                    n.sdo_bit = q.rd_sh[WORD_BITS-1];
                    n.rd_sh   = {q.rd_sh[WORD_BITS-2:0], 1'b0};
                    n.rcnt    = q.rcnt - 1'b1;
                    if (q.rcnt == DCW'(1)) begin
                        n.addr  = inc_addr;
                        n.rd_sh = ld_val;
                        n.rcnt  = dw;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sdo_en_o = sel_l && (busy || q.rdy_show || q.phase == PH_READ);
    assign sdo_o    = busy ? 1'b0 : ((q.phase == PH_READ) ? q.sdo_bit : 1'b1);

    assert_hiz_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_l |-> !sdo_en_o);
    assert_busy_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_l) |-> (sdo_en_o && !sdo_o));
    assert_locked_no_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.prog_en));
    assert_start_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sel_fall));
    assert_idle_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> q.phase == PH_IDLE);
endmodule

// File: tb/test_serial_eeprom_slave.sv
module test_serial_eeprom_slave;
    localparam int PROG = 400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, sdi = 1'b0, wide = 1'b1;
    logic sdo, sdo_en;

    always #4 clk = ~clk;

    serial_eeprom_slave #(.PROG_CYCLES(PROG)) i_serial_eeprom_slave (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
        .org16_i(wide), .sdo_o(sdo), .sdo_en_o(sdo_en)
    );

    int errors = 0, checks = 0;
    logic [15:0] mdl [64];
    bit en_m = 1'b0;

    function automatic void summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int k); repeat (k) @(negedge clk); endtask

    task automatic bitc(logic b);
        sdi = b; tick(4); sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    endtask

    task automatic head(logic [1:0] op, logic [6:0] a);
        bitc(1'b1); bitc(op[1]); bitc(op[0]);
        if (wide) for (int i = 5; i >= 0; i--) bitc(a[i]);
        else      for (int i = 6; i >= 0; i--) bitc(a[i]);
    endtask

    task automatic dat(logic [15:0] d);
        if (wide) for (int i = 15; i >= 0; i--) bitc(d[i]);
        else      for (int i = 7; i >= 0; i--) bitc(d[i]);
    endtask

    function automatic logic [15:0] mrd(logic [6:0] a);
        if (wide) return mdl[a[5:0]];
        return {8'h00, (a[0] ? mdl[a[6:1]][15:8] : mdl[a[6:1]][7:0])};
    endfunction

    function automatic void mwr(logic [6:0] a, logic [15:0] d);
        if (wide)      mdl[a[5:0]] = d;
        else if (a[0]) mdl[a[6:1]][15:8] = d[7:0];
        else           mdl[a[6:1]][7:0] = d[7:0];
    endfunction

    function automatic logic [6:0] spec(logic [1:0] top);
        return wide ? {1'b0, top, 4'b0} : {top, 5'b0};
    endfunction

    task automatic finish_prog(string req, bit run);
        int k;
        cs = 1'b0; tick(6); cs = 1'b1; tick(4);
        if (run) begin
            chk({req, " busy flag"}, {sdo_en, sdo}, 2'b10);
            k = 10;
            while (!(sdo_en && sdo) && k < PROG + 60) begin tick(1); k++; end
            chk("R10 cycle length in range", (k >= PROG && k <= PROG + 8), 1);
            chk("R9 ready flag", {sdo_en, sdo}, 2'b11);
        end else begin
            chk({req, " no cycle started"}, sdo_en, 1'b0);
        end
        cs = 1'b0; tick(4);
        chk("R9 hi-z when deselected", sdo_en, 1'b0);
    endtask

    task automatic wr(logic [6:0] a, logic [15:0] d, string req);
        cs = 1'b1; tick(2); head(2'b01, a); dat(d);
        if (en_m) mwr(a, d);
        finish_prog(req, en_m);
    endtask

    task automatic er(logic [6:0] a, string req);
        cs = 1'b1; tick(2); head(2'b11, a);
        if (en_m) mwr(a, 16'hFFFF);
        finish_prog(req, en_m);
    endtask

    task automatic lock(bit open);
        cs = 1'b1; tick(2); head(2'b00, spec(open ? 2'b11 : 2'b00));
        cs = 1'b0; tick(6); en_m = open;
    endtask

    task automatic rd(logic [6:0] a, int nw, int lead, string req);
        logic [6:0] cur;
        logic [15:0] val;
        cs = 1'b1; tick(2);
        for (int i = 0; i < lead; i++) bitc(1'b0);
        head(2'b10, a);
        chk({req, " R4 dummy zero"}, {sdo_en, sdo}, 2'b10);
        cur = a;
        for (int w = 0; w < nw; w++) begin
            val = '0;
            for (int b = 0; b < (wide ? 16 : 8); b++) begin
                bitc(1'b0);
                val = {val[14:0], sdo};
            end
            chk({req, " R5 read word"}, val, mrd(cur));
            cur = wide ? {1'b0, cur[5:0] + 6'd1} : cur + 7'd1;
        end
        cs = 1'b0; tick(6);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
        tick(3); rst_n = 1'b1; tick(3);
        chk("R9 reset output disabled", sdo_en, 1'b0);
        cs = 1'b1; tick(6);
        chk("R9 selected idle no drive", sdo_en, 1'b0);
        cs = 1'b0; tick(4);

        // R3: locked after reset, R8: array erased, R4 read while locked
        wr(7'd5, 16'h1234, "R3 locked write");
        rd(7'd5, 1, 0, "R8 reset ones R4 locked read");
        lock(1'b1);
        wr(7'd5, 16'hA5C3, "R7 write");
        rd(7'd5, 1, 2, "R1 leading zeros R8 write");
        wr(7'd5, 16'h0F0F, "R8 overwrite");
        rd(7'd5, 1, 0, "R8 overwrite");
        // R6 wrap
        wr(7'd63, 16'h1111, "R6 setup");
        wr(7'd0,  16'h2222, "R6 setup");
        rd(7'd62, 4, 0, "R6 wrap 16-bit");
        er(7'd5, "R8 erase");
        rd(7'd5, 1, 0, "R8 erase");

        // R12 byte mode mapping and wrap
        wide = 1'b0;
        wr(7'd10, 16'h003C, "R12 byte write");
        wr(7'd127, 16'h0081, "R12 byte write");
        rd(7'd127, 3, 0, "R6 wrap 8-bit");
        wide = 1'b1;
        rd(7'd5, 1, 0, "R12 word view");
        rd(7'd63, 1, 0, "R12 high byte");

        // R11 cut-short frame
        cs = 1'b1; tick(2); head(2'b01, 7'd12); bitc(1'b1); bitc(1'b0); bitc(1'b1);
        cs = 1'b0; tick(6); cs = 1'b1; tick(4);
        chk("R11 short frame no cycle", sdo_en, 1'b0);
        cs = 1'b0; tick(4);
        rd(7'd12, 1, 0, "R11 short frame unchanged");

        // R11 frame during busy
        cs = 1'b1; tick(2); head(2'b01, 7'd9); dat(16'h1357); mwr(7'd9, 16'h1357);
        cs = 1'b0; tick(6);
        cs = 1'b1; tick(2); head(2'b01, 7'd7); dat(16'h0000);
        chk("R11 still busy during frame", {sdo_en, sdo}, 2'b10);
        cs = 1'b0; tick(PROG);
        rd(7'd7, 1, 0, "R11 busy frame ignored");
        rd(7'd9, 1, 0, "R11 first write kept");

        // R2 whole-array instructions
        cs = 1'b1; tick(2); head(2'b00, spec(2'b01)); dat(16'hC0DE);
        for (int i = 0; i < 64; i++) mdl[i] = 16'hC0DE;
        finish_prog("R2 fill", 1'b1);
        rd(7'd30, 2, 0, "R2 fill");
        wide = 1'b0;
        cs = 1'b1; tick(2); head(2'b00, spec(2'b01)); dat(16'h005A);
        for (int i = 0; i < 64; i++) mdl[i] = 16'h5A5A;
        finish_prog("R2 fill byte", 1'b1);
        wide = 1'b1;
        rd(7'd40, 1, 0, "R2 fill byte");
        cs = 1'b1; tick(2); head(2'b00, spec(2'b10));
        for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
        finish_prog("R2 erase all", 1'b1);
        rd(7'd40, 1, 0, "R2 erase all");

        // R3 close lock
        lock(1'b0);
        wr(7'd3, 16'h0000, "R3 closed write");
        er(7'd3, "R3 closed erase");
        rd(7'd3, 1, 0, "R3 closed unchanged");
        lock(1'b1);

        // random mix
        for (int it = 0; it < 40; it++) begin
            logic [6:0] a;
            logic [15:0] d;
            int op;
            wide = 1'($urandom % 2);
            a = 7'($urandom);
            if (wide) a[6] = 1'b0;
            d = 16'($urandom);
            if (!wide) d[15:8] = 8'h00;
            op = $urandom % 4;
            case (op)
                0, 3: wr(a, d, "R8 random write");
                1:    er(a, "R8 random erase");
                default: rd(a, 2, 0, "R6 random read");
            endcase
        end
        wide = 1'b1;
        for (int i = 0; i < 64; i += 9) rd(7'(i), 1, 0, "R8 final sweep");

        summary();
        $finish;
    end
endmodule